// File: doc/BRIEF.md
# Branch-Resolving Fetch and Decode Front End

This block holds the program counter and the register between fetch and decode in a five-stage in-order pipeline. Fetch always assumes the next instruction is the one at the following word. Branch-if-equal is the only conditional branch. It is resolved in decode: a small equality comparator looks at the two operand values that come back from the register file.

When such a branch is taken, the instruction fetched behind it is wrong. It is replaced in the fetch/decode register by an all-zero no-op marked invalid, and the program counter jumps to the branch target. A taken branch therefore costs one bubble, and a branch that falls through costs nothing.

An external hazard unit can freeze the front end with a stall input. The register file is outside the block and is expected to read write-first, so the comparison sees current values.

Top module: `fetch_decode_front`

## Requirements
- R1: Synchronous reset (`rst` high) sets the fetch address to the reset vector (default 0). It also loads the fetch/decode register with instruction 32'h0000_0000, PC 0 and valid 0.
- R2: With no stall and no redirect, each clock edge does two things. It advances the fetch address by 4, and it loads the fetch/decode register with the fetched word, the address it came from and valid 1.
- R3: The register-file read addresses are taken from the fetch/decode instruction: bits [25:21] for port A and bits [20:16] for port B.
- R4: An instruction is a branch-if-equal when its bits [31:26] equal 6'h04. When the fetch/decode register holds a valid branch-if-equal and the two read values are equal, `redirect_o` is high in that same cycle. When the values differ, `redirect_o` stays low and fetch proceeds with no lost cycle.
- R5: The branch target is the branch's own PC plus the sign-extended 16-bit offset in bits [15:0], shifted left by 2. It becomes the fetch address at the clock edge that ends the redirect cycle. Negative offsets move backwards.
- R6: At that same edge the wrongly fetched instruction is discarded. The fetch/decode register is loaded with instruction 0, PC 0 and valid 0. The discarded instruction never reaches decode, so a branch among the discarded instructions has no effect.
- R7: While `stall_i` is high, the fetch address and the fetch/decode register hold their values. A stall takes priority over a redirect, and `redirect_o` is low during it. The branch takes effect once the stall ends.
- R8: An instruction whose opcode is not 6'h04 never causes a redirect, even when its two register fields read equal values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Hazard stall; freezes the program counter and the fetch/decode register |
| imem_addr_o | output | ADDR_W | Instruction memory read address (the program counter) |
| imem_rdata_i | input | 32 | Instruction word returned for `imem_addr_o` in the same cycle |
| rf_raddr_a_o | output | 5 | Register-file read address A |
| rf_raddr_b_o | output | 5 | Register-file read address B |
| rf_rdata_a_i | input | DATA_W | Register-file read data A |
| rf_rdata_b_i | input | DATA_W | Register-file read data B |
| ifid_instr_o | output | 32 | Instruction in decode |
| ifid_pc_o | output | ADDR_W | PC of the instruction in decode (0 for a bubble) |
| ifid_valid_o | output | 1 | Decode slot holds a real instruction |
| redirect_o | output | 1 | Taken branch-if-equal being applied this cycle |

## Verification
The bench places a second, always-taken branch directly behind a taken branch. A front end that failed to squash it would jump a second time to the wrong place. Fall-through branches and non-branch instructions with equal operands are run to show that no bubble and no redirect appear; a design that mis-decoded the opcode or inserted a bubble on every branch would show a shifted fetch address. A backward offset catches a missing sign extension, which would send fetch far forward. A stall held across a pending taken branch checks that the design neither jumps early nor drops the jump once the stall ends.

// File: rtl/fetch_decode_front.sv
module fetch_decode_front #(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] RESET_VEC = 32'h0000_0000,
  parameter logic [5:0]  BEQ_OP    = 6'h04,
  parameter int          ALIGN     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall_i,
  output logic [ADDR_W-1:0] imem_addr_o,
  input  logic [31:0]       imem_rdata_i,
  output logic [4:0]        rf_raddr_a_o,
  output logic [4:0]        rf_raddr_b_o,
  input  logic [DATA_W-1:0] rf_rdata_a_i,
  input  logic [DATA_W-1:0] rf_rdata_b_i,
  output logic [31:0]       ifid_instr_o,
  output logic [ADDR_W-1:0] ifid_pc_o,
  output logic              ifid_valid_o,
  output logic              redirect_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN;
  localparam logic [31:0]       NOP  = 32'h0;

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] offset, target;
  logic              is_beq, operands_eq;

  assign imem_addr_o  = pc_q;
  assign rf_raddr_a_o = ifid_instr_o[25:21];
  assign rf_raddr_b_o = ifid_instr_o[20:16];

  assign is_beq      = ifid_valid_o && (ifid_instr_o[31:26] == BEQ_OP);
  assign operands_eq = (rf_rdata_a_i == rf_rdata_b_i);
  assign redirect_o  = is_beq && operands_eq && !stall_i;

  assign offset = {{(ADDR_W-16){ifid_instr_o[15]}}, ifid_instr_o[15:0]} << ALIGN;
  assign target = ifid_pc_o + offset;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q         <= RESET_VEC[ADDR_W-1:0];
      ifid_instr_o <= NOP;
      ifid_pc_o    <= '0;
      ifid_valid_o <= 1'b0;
    end else if (stall_i) begin
      pc_q         <= pc_q;
    end else if (redirect_o) begin
      pc_q         <= target;
      ifid_instr_o <= NOP;
      ifid_pc_o    <= '0;
      ifid_valid_o <= 1'b0;
    end else begin
      pc_q         <= pc_q + STEP;
      ifid_instr_o <= imem_rdata_i;
      ifid_pc_o    <= pc_q;
      ifid_valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/fetch_decode_front_chk.sv
module fetch_decode_front_chk #(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] RESET_VEC = 32'h0000_0000,
  parameter logic [5:0]  BEQ_OP    = 6'h04,
  parameter int          ALIGN     = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              stall_i,
  input logic [ADDR_W-1:0] imem_addr_o,
  input logic [31:0]       imem_rdata_i,
  input logic [DATA_W-1:0] rf_rdata_a_i,
  input logic [DATA_W-1:0] rf_rdata_b_i,
  input logic [31:0]       ifid_instr_o,
  input logic [ADDR_W-1:0] ifid_pc_o,
  input logic              ifid_valid_o,
  input logic              redirect_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (imem_addr_o == RESET_VEC[ADDR_W-1:0]) && !ifid_valid_o && (ifid_instr_o == 32'h0));

  assert_seq_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && !redirect_o) |=> (imem_addr_o == $past(imem_addr_o) + STEP)
      && (ifid_pc_o == $past(imem_addr_o)) && (ifid_instr_o == $past(imem_rdata_i)) && ifid_valid_o);

  assert_redirect_cause_R4: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> ifid_valid_o && (ifid_instr_o[31:26] == BEQ_OP) && (rf_rdata_a_i == rf_rdata_b_i));

  assert_flush_bubble_R6: assert property (@(posedge clk) disable iff (rst)
    redirect_o |=> !ifid_valid_o && (ifid_instr_o == 32'h0) && (ifid_pc_o == '0));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    stall_i |=> $stable(imem_addr_o) && $stable(ifid_instr_o) && $stable(ifid_pc_o) && $stable(ifid_valid_o));

  assert_stall_no_redirect_R7: assert property (@(posedge clk) disable iff (rst)
    stall_i |-> !redirect_o);
endmodule

bind fetch_decode_front fetch_decode_front_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_VEC(RESET_VEC), .BEQ_OP(BEQ_OP), .ALIGN(ALIGN)
) u_chk (
  .clk(clk), .rst(rst), .stall_i(stall_i), .imem_addr_o(imem_addr_o),
  .imem_rdata_i(imem_rdata_i), .rf_rdata_a_i(rf_rdata_a_i), .rf_rdata_b_i(rf_rdata_b_i),
  .ifid_instr_o(ifid_instr_o), .ifid_pc_o(ifid_pc_o), .ifid_valid_o(ifid_valid_o),
  .redirect_o(redirect_o)
);

// File: tb/test_fetch_decode_front.sv
module test_fetch_decode_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [31:0] imem_addr, imem_rdata;
  logic [4:0]  ra, rb;
  logic [31:0] rda, rdb;
  logic [31:0] instr, ipc;
  logic        ivalid, redir;

  logic [31:0] mem [64];
  logic [31:0] rf  [32];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign imem_rdata = mem[imem_addr[7:2]];
  assign rda = rf[ra];
  assign rdb = rf[rb];

  fetch_decode_front i_fetch_decode_front (
    .clk(clk), .rst(rst), .stall_i(stall),
    .imem_addr_o(imem_addr), .imem_rdata_i(imem_rdata),
    .rf_raddr_a_o(ra), .rf_raddr_b_o(rb), .rf_rdata_a_i(rda), .rf_rdata_b_i(rdb),
    .ifid_instr_o(instr), .ifid_pc_o(ipc), .ifid_valid_o(ivalid), .redirect_o(redir)
  );

  function automatic logic [31:0] beq_i(int rs, int rt, int off);
    return {6'h04, 5'(rs), 5'(rt), 16'(off)};
  endfunction

  function automatic logic [31:0] alu_i(int rs, int rt, int k);
    return {6'h08, 5'(rs), 5'(rt), 16'(k)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_default();
    for (int i = 0; i < 64; i++) mem[i] = alu_i(0, 0, i + 100);
    for (int i = 0; i < 32; i++) rf[i] = 32'(i * 3 + 7);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    stall = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    load_default();
    do_reset();
    chk("R1 pc", imem_addr, 32'h0);
    chk("R1 instr", instr, 32'h0);
    chk("R1 valid", 32'(ivalid), 32'h0);
    chk("R1 ifid pc", ipc, 32'h0);
  endtask

  task automatic t_seq();
    load_default();
    do_reset();
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk("R2 pc advance", imem_addr, 32'(4 * k));
      chk("R2 ifid instr", instr, mem[k - 1]);
      chk("R2 ifid pc", ipc, 32'(4 * (k - 1)));
      chk("R2 valid", 32'(ivalid), 32'h1);
    end
  endtask

  task automatic t_taken();
    load_default();
    mem[1] = beq_i(1, 2, 3);
    mem[2] = beq_i(3, 3, 10);
    rf[2] = rf[1];
    do_reset();
    repeat (2) @(negedge clk);
    chk("R3 raddr a", 32'(ra), 32'd1);
    chk("R3 raddr b", 32'(rb), 32'd2);
    chk("R4 redirect taken", 32'(redir), 32'h1);
    @(negedge clk);
    chk("R5 target pc", imem_addr, 32'd16);
    chk("R6 bubble instr", instr, 32'h0);
    chk("R6 bubble valid", 32'(ivalid), 32'h0);
    chk("R6 bubble pc", ipc, 32'h0);
    chk("R6 no redirect on bubble", 32'(redir), 32'h0);
    @(negedge clk);
    chk("R6 target instr", instr, mem[4]);
    chk("R6 target ifid pc", ipc, 32'd16);
    chk("R6 squashed branch ignored", imem_addr, 32'd20);
  endtask

  task automatic t_not_taken();
    load_default();
    mem[1] = beq_i(1, 2, 3);
    do_reset();
    repeat (2) @(negedge clk);
    chk("R4 no redirect unequal", 32'(redir), 32'h0);
    @(negedge clk);
    chk("R4 fall-through pc", imem_addr, 32'd12);
    chk("R4 fall-through instr", instr, mem[2]);
    chk("R4 fall-through valid", 32'(ivalid), 32'h1);
  endtask

  task automatic t_negative();
    load_default();
    mem[3] = beq_i(4, 5, -3);
    rf[5] = rf[4];
    do_reset();
    repeat (4) @(negedge clk);
    chk("R4 backward redirect", 32'(redir), 32'h1);
    @(negedge clk);
    chk("R5 backward target", imem_addr, 32'h0);
    @(negedge clk);
    chk("R5 backward instr", instr, mem[0]);
    chk("R5 backward ifid pc", ipc, 32'h0);
  endtask

  task automatic t_stall();
    load_default();
    do_reset();
    @(negedge clk);
    stall = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 pc held", imem_addr, 32'd4);
    chk("R7 instr held", instr, mem[0]);
    chk("R7 ifid pc held", ipc, 32'h0);
    stall = 1'b0;
    @(negedge clk);
    chk("R7 resume pc", imem_addr, 32'd8);
    chk("R7 resume instr", instr, mem[1]);
  endtask

  task automatic t_stall_redirect();
    load_default();
    mem[1] = beq_i(1, 2, 3);
    rf[2] = rf[1];
    do_reset();
    repeat (2) @(negedge clk);
    stall = 1'b1;
    #1;
    chk("R7 redirect masked", 32'(redir), 32'h0);
    repeat (2) @(negedge clk);
    chk("R7 pc held over redirect", imem_addr, 32'd8);
    chk("R7 branch held", instr, mem[1]);
    stall = 1'b0;
    #1;
    chk("R7 redirect after stall", 32'(redir), 32'h1);
    @(negedge clk);
    chk("R7 late target", imem_addr, 32'd16);
    chk("R7 late bubble", 32'(ivalid), 32'h0);
  endtask

  task automatic t_non_beq();
    load_default();
    mem[1] = alu_i(1, 1, 3);
    do_reset();
    repeat (2) @(negedge clk);
    chk("R8 no redirect", 32'(redir), 32'h0);
    @(negedge clk);
    chk("R8 sequential pc", imem_addr, 32'd12);
    chk("R8 sequential instr", instr, mem[2]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_seq();
    t_taken();
    t_not_taken();
    t_negative();
    t_stall();
    t_stall_redirect();
    t_non_beq();
    finish_run();
  end
endmodule